// File: doc/BRIEF.md
# Directed-Rounding Increment Stage

This block is one pipeline step of a floating-point result packer. The caller hands it a mantissa whose two lowest bits are the guard bit (the upper of the two) and the round bit (the lower one). It also gives a separate sticky bit, the sign of the value and a two-bit rounding-mode code. One clock later the block returns the mantissa with those two bits dropped. Where the mode calls for it, that mantissa is incremented by one with full carry propagation. The block also returns status: whether the value was inexact, whether it was bumped upward, and, for a caller that has already detected exponent overflow, whether the overflow should saturate to infinity or to the largest finite magnitude.

Renormalising after a carry out of the top bit and adjusting the exponent are left to the caller. The output is one bit wider than the shifted mantissa, so a full carry is passed through unchanged as the value 2.0. Inputs are captured only in cycles where `in_valid` is high. The outputs hold their last result otherwise.

Top module: `rnd_stage`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_mant` after that edge equals `in_mant >> 2` plus one if an increment is chosen, and `out_valid` is high. The result is WIDTH-1 bits wide.
- R2: If guard (`in_mant[1]`), round (`in_mant[0]`) and `in_sticky` are all zero, no increment happens and `out_inexact`, `out_frac_inexact`, `out_frac_rounded` and `out_up` are all low.
- R3: If any of guard, round or sticky is set, both `out_inexact` and `out_frac_inexact` are high.
- R4: Mode code 2'b00 is round-to-nearest. It increments only when guard is set and at least one of round, sticky, or bit 2 of `in_mant` (the LSB after the shift) is set, giving ties-to-even.
- R5: Mode code 2'b01 (toward zero) never increments. Mode 2'b10 (toward plus infinity) increments an inexact value only when `in_sign` is 0. Mode 2'b11 (toward minus infinity) increments an inexact value only when `in_sign` is 1.
- R6: Whenever an increment happens, `out_up` and `out_frac_rounded` are high. The carry runs through the whole mantissa, so an all-ones shifted value becomes 2^(WIDTH-2) with no correction.
- R7: `out_to_inf` is 1 for nearest mode, 0 for toward-zero mode, 1 in plus mode only for a positive sign, and 1 in minus mode only for a negative sign. `out_ovf_flag` is high only when `in_ovf` was high and `out_to_inf` is 1.
- R8: In a cycle where `in_valid` is low, `out_valid` goes low and every other output keeps its value.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block synchronises its release internally |
| in_valid | input | 1 | Capture enable for the operand |
| in_mant | input | WIDTH | Mantissa with guard at bit 1 and round at bit 0 |
| in_sticky | input | 1 | OR of every bit below the round bit |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_ovf | input | 1 | Caller reports exponent overflow for this operand |
| out_valid | output | 1 | A result was captured in the last cycle |
| out_mant | output | WIDTH-1 | Shifted and possibly incremented mantissa, carry bit on top |
| out_up | output | 1 | The mantissa was incremented |
| out_inexact | output | 1 | Inexact, for accumulation into a sticky status |
| out_frac_inexact | output | 1 | Fraction inexact for this operation |
| out_frac_rounded | output | 1 | Fraction was rounded upward |
| out_to_inf | output | 1 | Overflow direction: 1 = infinity, 0 = largest finite |
| out_ovf_flag | output | 1 | Overflow status, raised only when infinity is chosen |

## Verification
A wrong increment decision shows up as `out_mant` off by exactly one, and `out_up` wrong, in the first cycle after the operand is captured. No state carries over to later operands, so every error is visible on the same vector that caused it. A broken capture enable shows up as outputs changing during an idle cycle. Carry faults appear only when the shifted mantissa is all ones, so that pattern is tested directly.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS     = 2'b10,
    RM_NEG     = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/rnd_rst_sync.sv
module rnd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      guard_bit,
  input  logic      round_bit,
  input  logic      sticky_bit,
  input  logic      kept_lsb,
  input  logic      sign_bit,
  input  logic [1:0] mode,
  output logic      inexact,
  output logic      incr
);
  logic want;

  assign inexact = guard_bit | round_bit | sticky_bit;

  always_comb begin
    case (mode)
      RM_ZERO: want = 1'b0;
      RM_POS:  want = ~sign_bit;
      RM_NEG:  want = sign_bit;
      default: want = guard_bit & (round_bit | sticky_bit | kept_lsb);
    endcase
    incr = want & inexact;
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int KW = 24
) (
  input  logic [KW-1:0] kept,
  input  logic          bump,
  output logic [KW:0]   sum
);
  assign sum = {1'b0, kept} + {{KW{1'b0}}, bump};
endmodule

// File: rtl/rnd_ovf_dir.sv
module rnd_ovf_dir
  import rnd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       sign_bit,
  output logic       to_inf
);
  always_comb begin
    case (mode)
      RM_ZERO: to_inf = 1'b0;
      RM_POS:  to_inf = ~sign_bit;
      RM_NEG:  to_inf = sign_bit;
      default: to_inf = 1'b1;
    endcase
  end
endmodule

// File: rtl/rnd_stage.sv
module rnd_stage #(
  parameter int WIDTH = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_mant,
  input  logic             in_sticky,
  input  logic             in_sign,
  input  logic [1:0]       in_mode,
  input  logic             in_ovf,
  output logic             out_valid,
  output logic [WIDTH-2:0] out_mant,
  output logic             out_up,
  output logic             out_inexact,
  output logic             out_frac_inexact,
  output logic             out_frac_rounded,
  output logic             out_to_inf,
  output logic             out_ovf_flag
);
  localparam int KW = WIDTH - 2;

  logic          rst_sync_n;
  logic          inexact_c, incr_c, to_inf_c;
  logic [KW:0]   sum_c;

  logic             valid_d, up_d, inx_d, frnd_d, inf_d, oflag_d;
  logic [WIDTH-2:0] mant_d;

  rnd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  rnd_decide u_dec (
    .guard_bit(in_mant[1]), .round_bit(in_mant[0]), .sticky_bit(in_sticky),
    .kept_lsb(in_mant[2]), .sign_bit(in_sign), .mode(in_mode),
    .inexact(inexact_c), .incr(incr_c)
  );

  rnd_incr #(.KW(KW)) u_inc (
    .kept(in_mant[WIDTH-1:2]), .bump(incr_c), .sum(sum_c)
  );

  rnd_ovf_dir u_dir (
    .mode(in_mode), .sign_bit(in_sign), .to_inf(to_inf_c)
  );

  // next-state
  always_comb begin
    valid_d = in_valid;
    mant_d  = out_mant;
    up_d    = out_up;
    inx_d   = out_inexact;
    frnd_d  = out_frac_rounded;
    inf_d   = out_to_inf;
    oflag_d = out_ovf_flag;
    if (in_valid) begin
      mant_d  = sum_c;
      up_d    = incr_c;
      inx_d   = inexact_c;
      frnd_d  = incr_c;
      inf_d   = to_inf_c;
      oflag_d = in_ovf & to_inf_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid        <= 1'b0;
      out_mant         <= '0;
      out_up           <= 1'b0;
      out_inexact      <= 1'b0;
      out_frac_rounded <= 1'b0;
      out_to_inf       <= 1'b0;
      out_ovf_flag     <= 1'b0;
    end else begin
      out_valid        <= valid_d;
      out_mant         <= mant_d;
      out_up           <= up_d;
      out_inexact      <= inx_d;
      out_frac_rounded <= frnd_d;
      out_to_inf       <= inf_d;
      out_ovf_flag     <= oflag_d;
    end
  end

  assign out_frac_inexact = out_inexact;
endmodule

// File: rtl/rnd_stage_chk.sv
module rnd_stage_chk #(
  parameter int WIDTH = 26
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_mant,
  input logic             in_sticky,
  input logic             in_sign,
  input logic [1:0]       in_mode,
  input logic             in_ovf,
  input logic             out_valid,
  input logic [WIDTH-2:0] out_mant,
  input logic             out_up,
  input logic             out_inexact,
  input logic             out_frac_inexact,
  input logic             out_frac_rounded,
  input logic             out_to_inf,
  input logic             out_ovf_flag
);
  p_sum_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid &&
      out_mant == ({1'b0, $past(in_mant[WIDTH-1:2])} + {{(WIDTH-2){1'b0}}, out_up}));

  p_exact_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=>
      !out_up && !out_inexact && !out_frac_rounded);

  p_inexact_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && (in_mant[1:0] != 2'b00 || in_sticky)) |=>
      out_inexact && out_frac_inexact);

  p_no_guard_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_mode == 2'b00 && !in_mant[1]) |=> !out_up);

  p_zero_mode_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_mode == 2'b01) |=> !out_up && !out_to_inf);

  p_up_flag_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && out_up) |-> out_frac_rounded && out_inexact);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    out_ovf_flag |-> out_to_inf);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid && $stable(out_mant) && $stable(out_up) && $stable(out_to_inf));
endmodule

bind rnd_stage rnd_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .in_valid(in_valid), .in_mant(in_mant),
  .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode), .in_ovf(in_ovf),
  .out_valid(out_valid), .out_mant(out_mant), .out_up(out_up),
  .out_inexact(out_inexact), .out_frac_inexact(out_frac_inexact),
  .out_frac_rounded(out_frac_rounded), .out_to_inf(out_to_inf),
  .out_ovf_flag(out_ovf_flag)
);

// File: tb/rnd_stage_tb.sv
module rnd_stage_tb;
  localparam int W = 26;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sticky, in_sign, in_ovf;
  logic [W-1:0] in_mant;
  logic [1:0] in_mode;
  logic out_valid, out_up, out_inexact, out_frac_inexact, out_frac_rounded;
  logic out_to_inf, out_ovf_flag;
  logic [W-2:0] out_mant;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  rnd_stage #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode), .in_ovf(in_ovf),
    .out_valid(out_valid), .out_mant(out_mant), .out_up(out_up),
    .out_inexact(out_inexact), .out_frac_inexact(out_frac_inexact),
    .out_frac_rounded(out_frac_rounded), .out_to_inf(out_to_inf),
    .out_ovf_flag(out_ovf_flag)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Drive one operand at a falling edge, sample after the capturing edge.
  task automatic apply(input logic [W-3:0] kept, input logic [1:0] gr, input logic st,
                       input logic sg, input logic [1:0] md, input logic ov);
    @(negedge clk);
    in_valid = 1'b1; in_mant = {kept, gr}; in_sticky = st;
    in_sign = sg; in_mode = md; in_ovf = ov;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Independent model from the requirements; checks all outputs.
  task automatic run(input string req, input logic [W-3:0] kept, input logic [1:0] gr,
                     input logic st, input logic sg, input logic [1:0] md, input logic ov);
    logic inx, up, inf;
    longint emant;
    inx = (gr != 2'b00) || st;
    if (md == 2'b01) up = 1'b0;
    else if (md == 2'b10) up = inx && !sg;
    else if (md == 2'b11) up = inx && sg;
    else up = gr[1] && (gr[0] || st || kept[0]);
    inf = (md == 2'b00) ? 1'b1 : (md == 2'b01) ? 1'b0 : (md == 2'b10) ? !sg : sg;
    emant = longint'(kept) + (up ? 1 : 0);
    apply(kept, gr, st, sg, md, ov);
    chk({req, " valid R1"}, out_valid, 1);
    chk({req, " mant"}, out_mant, emant);
    chk({req, " up R6"}, out_up, up);
    chk({req, " rounded R6"}, out_frac_rounded, up);
    chk({req, " inexact R3"}, out_inexact, inx);
    chk({req, " finexact R3"}, out_frac_inexact, inx);
    chk({req, " toinf R7"}, out_to_inf, inf);
    chk({req, " ovflag R7"}, out_ovf_flag, ov && inf);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_mant = '0; in_sticky = 1'b0;
    in_sign = 1'b0; in_mode = 2'b00; in_ovf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset valid", out_valid, 0);
    chk("R9 reset mant", out_mant, 0);
    chk("R9 reset flags", {out_up, out_inexact, out_frac_rounded, out_to_inf, out_ovf_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_exact;
    for (int m = 0; m < 4; m++) run("R2 exact", 24'h123456, 2'b00, 1'b0, m[0], m[1:0], 1'b0);
  endtask

  task automatic t_nearest;
    run("R4 tie even", 24'h000010, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0);
    run("R4 tie odd", 24'h000011, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0);
    run("R4 above half", 24'h000010, 2'b11, 1'b0, 1'b1, 2'b00, 1'b0);
    run("R4 sticky", 24'h000010, 2'b10, 1'b1, 1'b0, 2'b00, 1'b0);
    run("R4 below half", 24'h000011, 2'b01, 1'b1, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_directed;
    for (int s = 0; s < 2; s++) begin
      run("R5 zero", 24'h0ABCDE, 2'b11, 1'b1, s[0], 2'b01, 1'b0);
      run("R5 plus", 24'h0ABCDE, 2'b01, 1'b0, s[0], 2'b10, 1'b0);
      run("R5 minus", 24'h0ABCDE, 2'b00, 1'b1, s[0], 2'b11, 1'b0);
    end
  endtask

  task automatic t_carry;
    run("R6 carry", 24'hFFFFFF, 2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R6 two point zero", out_mant, 64'h1000000);
    run("R6 carry plus", 24'hFFFFFF, 2'b00, 1'b1, 1'b0, 2'b10, 1'b0);
  endtask

  task automatic t_overflow;
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        run("R7 ovf", 24'hFFFFFF, 2'b00, 1'b0, s[0], m[1:0], 1'b1);
  endtask

  task automatic t_hold;
    logic [W-2:0] m0;
    run("R8 setup", 24'h00F00F, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
    m0 = out_mant;
    @(negedge clk);
    in_mant = '1; in_sticky = 1'b1; in_mode = 2'b10; in_sign = 1'b1; in_ovf = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 hold valid", out_valid, 0);
    chk("R8 hold mant", out_mant, m0);
    chk("R8 hold flags", {out_up, out_inexact, out_to_inf, out_ovf_flag}, 4'b1111);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_exact();
        t_nearest();
        t_directed();
        t_carry();
        t_overflow();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule